// File: doc/BRIEF.md
# Binary128 sign-inject, min/max and compare unit

This unit performs the non-arithmetic two-operand operations on 128-bit IEEE binary128 values: it has 1 sign bit, 15 exponent bits and 112 fraction bits. It decodes a 32-bit floating-point instruction word and selects one of eight operations:

- three sign-injection forms
- minimum and maximum
- three ordered comparisons

The two operands come in as separate 128-bit buses. Register reads and the register file lie outside the block.

Results are registered once. A floating-point result, a one-bit comparison result for an integer destination, and a five-bit accrued exception vector all appear together with `valid_o`, one clock after `valid_i`. Min/max and the comparisons handle signaling and quiet NaNs and signed zeros. Sign injection moves the bits through untouched.

Top module: `qfp_misc_unit`

## Requirements
- R1: An instruction is accepted only when bits [6:0] equal 1010011 and the pair {bits[31:25], bits[14:12]} is one of the following: 0010011/000 plain inject, 0010011/001 negated inject, 0010011/010 XOR inject, 0010111/000 minimum, 0010111/001 maximum, 1010011/010 equal, 1010011/001 less-than, 1010011/000 less-or-equal. An accepted instruction with `valid_i` high raises `valid_o` on the next clock. For any other word, or when `valid_i` is low, `valid_o` is low and `fp_res_o`, `cmp_o` and `flags_o` are all zero on the next clock.
- R2: The plain inject result is operand A's bits [126:0] with operand B's sign. The negated form uses B's inverted sign. The XOR form uses the XOR of both signs.
- R3: Sign injection never raises a flag, and it passes NaN payloads through unchanged, signaling NaNs included.
- R4: When neither operand is NaN, minimum returns A if A is below B and otherwise B. Maximum returns A if B is below A and otherwise B.
- R5: For minimum and maximum, -0 (sign bit 127 set, all other bits zero) counts as below +0.
- R6: If exactly one min/max operand is NaN, the other operand is returned. If both are NaN, the result is the canonical NaN 0x7FFF8000_00000000_00000000_00000000.
- R7: Min/max raises invalid only when an operand is a signaling NaN (exponent all ones, fraction bit 111 clear, fraction nonzero). Quiet NaNs (fraction bit 111 set) raise nothing.
- R8: Equal, less-than and less-or-equal drive `cmp_o` with the ordered result, and +0 and -0 compare equal. Any NaN operand gives 0.
- R9: Equal raises invalid only for a signaling NaN. Less-than and less-or-equal raise invalid for any NaN.
- R10: `flags_o` is {invalid, divide-by-zero, overflow, underflow, inexact} with invalid at bit 4. Bits [3:0] are always zero. `fp_res_o` is zero for compare operations, and `cmp_o` is zero for the other operations.
- R11: While `rst_ni` is low, and after reset until the first accepted instruction, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction and operands present |
| instr_i | input | 32 | Floating-point instruction word |
| op_a_i | input | 128 | First source operand (rs1 value) |
| op_b_i | input | 128 | Second source operand (rs2 value) |
| valid_o | output | 1 | Registered results valid |
| fp_res_o | output | 128 | Floating-point result |
| cmp_o | output | 1 | Comparison result for integer destination |
| flags_o | output | 5 | Accrued exception flags |

## Verification
The assertions check the following on every cycle:
- the one-cycle link between `valid_i` and `valid_o`
- zeroed outputs when nothing valid was issued
- flag bits [3:0] held at zero
- sign injection keeping A's magnitude and raising no flag
- compare operations leaving `fp_res_o` at zero
- a NaN-free min/max always returning one of its two operands

Only the bench's scenarios can show which operand min/max actually picks, the signed-zero ordering, the canonical-NaN substitution, the comparison truth values, and the exact conditions under which invalid is raised, since each needs an expected value for a chosen operand pair.

// File: rtl/qfp_pkg.sv
package qfp_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam logic [6:0] OPC_FP   = 7'b1010011;
  localparam logic [6:0] F7_SGNJ  = 7'b0010011;
  localparam logic [6:0] F7_MINMX = 7'b0010111;
  localparam logic [6:0] F7_CMP   = 7'b1010011;
  localparam int unsigned FLAG_W  = 5;
  localparam int unsigned FLAG_NV = 4;

  typedef enum logic [3:0] {
    OP_NONE, OP_SGNJ, OP_SGNJN, OP_SGNJX, OP_MIN, OP_MAX, OP_FEQ, OP_FLT, OP_FLE
  } qfp_op_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic sign;
  } qfp_cls_t;
endpackage

// File: rtl/qfp_decode.sv
module qfp_decode
  import qfp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output qfp_op_e            op_o
);
  logic [6:0] f7;
  logic [2:0] f3;
  assign f7 = instr_i[31:25];
  assign f3 = instr_i[14:12];

  always_comb begin
    op_o = OP_NONE;
    if (instr_i[6:0] == OPC_FP) begin
      unique case ({f7, f3})
        {F7_SGNJ,  3'b000}: op_o = OP_SGNJ;
        {F7_SGNJ,  3'b001}: op_o = OP_SGNJN;
        {F7_SGNJ,  3'b010}: op_o = OP_SGNJX;
        {F7_MINMX, 3'b000}: op_o = OP_MIN;
        {F7_MINMX, 3'b001}: op_o = OP_MAX;
        {F7_CMP,   3'b010}: op_o = OP_FEQ;
        {F7_CMP,   3'b001}: op_o = OP_FLT;
        {F7_CMP,   3'b000}: op_o = OP_FLE;
        default:            op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/qfp_classify.sv
module qfp_classify
  import qfp_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112,
  localparam int unsigned FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [FP_W-1:0] val_i,
  output qfp_cls_t        cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  assign exp_f  = val_i[FP_W-2 -: EXP_W];
  assign frac_f = val_i[FRAC_W-1:0];

  always_comb begin
    cls_o.sign    = val_i[FP_W-1];
    cls_o.is_nan  = (&exp_f) && (|frac_f);
    cls_o.is_snan = cls_o.is_nan && !frac_f[FRAC_W-1];
    cls_o.is_zero = (val_i[FP_W-2:0] == '0);
  end
endmodule

// File: rtl/qfp_compare.sv
module qfp_compare
  import qfp_pkg::*;
#(
  parameter int unsigned FP_W = 128
) (
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  qfp_cls_t        cls_a_i,
  input  qfp_cls_t        cls_b_i,
  output logic            unord_o,
  output logic            eq_o,
  output logic            lt_ab_o,
  output logic            tot_lt_ab_o,
  output logic            tot_lt_ba_o
);
  logic [FP_W-2:0] mag_a, mag_b;
  logic both_zero, lt_ba;
  assign mag_a     = a_i[FP_W-2:0];
  assign mag_b     = b_i[FP_W-2:0];
  assign both_zero = cls_a_i.is_zero && cls_b_i.is_zero;
  assign unord_o   = cls_a_i.is_nan || cls_b_i.is_nan;

  // ordered relations, valid only when !unord_o
  always_comb begin
    eq_o = both_zero || (a_i == b_i);
    if (both_zero) begin
      lt_ab_o = 1'b0;
      lt_ba   = 1'b0;
    end else if (cls_a_i.sign != cls_b_i.sign) begin
      lt_ab_o = cls_a_i.sign;
      lt_ba   = cls_b_i.sign;
    end else if (!cls_a_i.sign) begin
      lt_ab_o = mag_a < mag_b;
      lt_ba   = mag_b < mag_a;
    end else begin
      lt_ab_o = mag_a > mag_b;
      lt_ba   = mag_b > mag_a;
    end
  end

  // min/max ordering: -0 below +0
  assign tot_lt_ab_o = lt_ab_o || (both_zero && cls_a_i.sign && !cls_b_i.sign);
  assign tot_lt_ba_o = lt_ba   || (both_zero && cls_b_i.sign && !cls_a_i.sign);
endmodule

// File: rtl/qfp_misc_unit.sv
module qfp_misc_unit
  import qfp_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112,
  localparam int unsigned FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [FP_W-1:0]    op_a_i,
  input  logic [FP_W-1:0]    op_b_i,
  output logic               valid_o,
  output logic [FP_W-1:0]    fp_res_o,
  output logic               cmp_o,
  output logic [FLAG_W-1:0]  flags_o
);
  localparam logic [FP_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  qfp_op_e        op;
  logic [FP_W-1:0] opnd [2];
  qfp_cls_t       cls  [2];
  logic unord, eq, lt_ab, tot_lt_ab, tot_lt_ba, any_snan;
  logic [FP_W-1:0]   fp_d;
  logic              cmp_d, nv_d, acc;

  assign opnd[0] = op_a_i;
  assign opnd[1] = op_b_i;

  qfp_decode u_dec (.instr_i(instr_i), .op_o(op));

  for (genvar g = 0; g < 2; g++) begin : g_cls
    qfp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i(opnd[g]), .cls_o(cls[g]));
  end

  qfp_compare #(.FP_W(FP_W)) u_cmp (
    .a_i(op_a_i), .b_i(op_b_i), .cls_a_i(cls[0]), .cls_b_i(cls[1]),
    .unord_o(unord), .eq_o(eq), .lt_ab_o(lt_ab),
    .tot_lt_ab_o(tot_lt_ab), .tot_lt_ba_o(tot_lt_ba));

  assign any_snan = cls[0].is_snan || cls[1].is_snan;
  assign acc      = valid_i && (op != OP_NONE);

  always_comb begin
    fp_d  = '0;
    cmp_d = 1'b0;
    nv_d  = 1'b0;
    unique case (op)
      OP_SGNJ:  fp_d = {op_b_i[FP_W-1], op_a_i[FP_W-2:0]};
      OP_SGNJN: fp_d = {~op_b_i[FP_W-1], op_a_i[FP_W-2:0]};
      OP_SGNJX: fp_d = {op_a_i[FP_W-1] ^ op_b_i[FP_W-1], op_a_i[FP_W-2:0]};
      OP_MIN, OP_MAX: begin
        nv_d = any_snan;
        if (cls[0].is_nan && cls[1].is_nan) fp_d = CANON_NAN;
        else if (cls[0].is_nan)             fp_d = op_b_i;
        else if (cls[1].is_nan)             fp_d = op_a_i;
        else if (op == OP_MIN)              fp_d = tot_lt_ab ? op_a_i : op_b_i;
        else                                fp_d = tot_lt_ba ? op_a_i : op_b_i;
      end
      OP_FEQ: begin
        nv_d  = any_snan;
        cmp_d = !unord && eq;
      end
      OP_FLT: begin
        nv_d  = unord;
        cmp_d = !unord && lt_ab;
      end
      OP_FLE: begin
        nv_d  = unord;
        cmp_d = !unord && (lt_ab || eq);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      fp_res_o <= '0;
      cmp_o    <= 1'b0;
      flags_o  <= '0;
    end else begin
      valid_o  <= acc;
      fp_res_o <= acc ? fp_d  : '0;
      cmp_o    <= acc ? cmp_d : 1'b0;
      flags_o  <= acc ? (FLAG_W'(nv_d) << FLAG_NV) : '0;
    end
  end
endmodule

// File: rtl/qfp_misc_unit_chk.sv
module qfp_misc_unit_chk
  import qfp_pkg::*;
#(
  parameter int unsigned FP_W  = 128,
  parameter int unsigned EXP_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [FP_W-1:0]    op_a_i,
  input logic [FP_W-1:0]    op_b_i,
  input logic               valid_o,
  input logic [FP_W-1:0]    fp_res_o,
  input logic               cmp_o,
  input logic [FLAG_W-1:0]  flags_o
);
  logic fp_opc, is_sgnj, is_mm, is_cmp, a_nan, b_nan;
  assign fp_opc  = instr_i[6:0] == OPC_FP;
  assign is_sgnj = fp_opc && instr_i[31:25] == F7_SGNJ  && instr_i[14:12] <= 3'd2;
  assign is_mm   = fp_opc && instr_i[31:25] == F7_MINMX && instr_i[14:12] <= 3'd1;
  assign is_cmp  = fp_opc && instr_i[31:25] == F7_CMP   && instr_i[14:12] <= 3'd2;
  assign a_nan   = (&op_a_i[FP_W-2 -: EXP_W]) && (|op_a_i[FP_W-EXP_W-2:0]);
  assign b_nan   = (&op_b_i[FP_W-2 -: EXP_W]) && (|op_b_i[FP_W-EXP_W-2:0]);

  // R1
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (fp_res_o == '0 && !cmp_o && flags_o == '0));
  // R10
  flag_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'd0);
  // R3
  sgnj_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(is_sgnj)) |-> flags_o == '0);
  // R2
  sgnj_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(is_sgnj)) |-> fp_res_o[FP_W-2:0] == $past(op_a_i[FP_W-2:0]));
  // R10
  cmp_fpzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(is_cmp)) |-> fp_res_o == '0);
  // R4
  mm_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(is_mm) && !$past(a_nan) && !$past(b_nan)) |->
      (fp_res_o == $past(op_a_i) || fp_res_o == $past(op_b_i)));
endmodule

bind qfp_misc_unit qfp_misc_unit_chk #(.FP_W(FP_W), .EXP_W(EXP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
  .op_a_i(op_a_i), .op_b_i(op_b_i), .valid_o(valid_o), .fp_res_o(fp_res_o),
  .cmp_o(cmp_o), .flags_o(flags_o));

// File: tb/qfp_misc_unit_bench.sv
module qfp_misc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] op_a_i = '0, op_b_i = '0;
  logic         valid_o, cmp_o;
  logic [127:0] fp_res_o;
  logic [4:0]   flags_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  qfp_misc_unit u_qfp_misc_unit (.*);

  localparam logic [127:0] ONE    = {1'b0, 15'h3FFF, 112'd0};
  localparam logic [127:0] TWO    = {1'b0, 15'h4000, 112'd0};
  localparam logic [127:0] NONE   = {1'b1, 15'h3FFF, 112'd0};
  localparam logic [127:0] NTWO   = {1'b1, 15'h4000, 112'd0};
  localparam logic [127:0] PZ     = 128'd0;
  localparam logic [127:0] NZ     = {1'b1, 127'd0};
  localparam logic [127:0] QNAN   = {1'b0, 15'h7FFF, 1'b1, 111'h5};
  localparam logic [127:0] SNAN   = {1'b0, 15'h7FFF, 1'b0, 111'h9};
  localparam logic [127:0] CANON  = {1'b0, 15'h7FFF, 1'b1, 111'd0};
  localparam logic [4:0]   NV     = 5'b10000;

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3);
    return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b1010011};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] ins, input logic vi,
                     input logic [127:0] a, input logic [127:0] b,
                     input logic ev, input logic [127:0] efp, input logic ecmp,
                     input logic [4:0] efl);
    @(negedge clk_i);
    valid_i = vi; instr_i = ins; op_a_i = a; op_b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid"}, 128'(valid_o), 128'(ev));
    chk({req, " fp"},    fp_res_o, efp);
    chk({req, " cmp"},   128'(cmp_o), 128'(ecmp));
    chk({req, " flags"}, 128'(flags_o), 128'(efl));
  endtask

  task automatic t_reset();
    // R11
    chk("R11 valid", 128'(valid_o), 0);
    chk("R11 fp", fp_res_o, 0);
    chk("R11 flags", 128'({cmp_o, flags_o}), 0);
  endtask

  task automatic t_sgnj();
    run("R2 plain",  mk(7'b0010011, 3'b000), 1, ONE,  NTWO, 1, NONE, 0, 0);
    run("R2 negate", mk(7'b0010011, 3'b001), 1, ONE,  NTWO, 1, ONE,  0, 0);
    run("R2 xor",    mk(7'b0010011, 3'b010), 1, NONE, NTWO, 1, ONE,  0, 0);
    run("R3 snan payload", mk(7'b0010011, 3'b001), 1, SNAN, ONE, 1, {1'b1, SNAN[126:0]}, 0, 0);
  endtask

  task automatic t_minmax();
    run("R4 min",     mk(7'b0010111, 3'b000), 1, ONE,  TWO,  1, ONE,  0, 0);
    run("R4 max",     mk(7'b0010111, 3'b001), 1, ONE,  TWO,  1, TWO,  0, 0);
    run("R4 min neg", mk(7'b0010111, 3'b000), 1, NONE, ONE,  1, NONE, 0, 0);
    run("R4 max neg", mk(7'b0010111, 3'b001), 1, NTWO, NONE, 1, NONE, 0, 0);
  endtask

  task automatic t_zero();
    run("R5 min +0,-0", mk(7'b0010111, 3'b000), 1, PZ, NZ, 1, NZ, 0, 0);
    run("R5 max -0,+0", mk(7'b0010111, 3'b001), 1, NZ, PZ, 1, PZ, 0, 0);
    run("R5 min -0,+0", mk(7'b0010111, 3'b000), 1, NZ, PZ, 1, NZ, 0, 0);
  endtask

  task automatic t_nan_mm();
    run("R6 min qnan,x", mk(7'b0010111, 3'b000), 1, QNAN, TWO,  1, TWO,   0, 0);
    run("R6 max x,qnan", mk(7'b0010111, 3'b001), 1, ONE,  QNAN, 1, ONE,   0, 0);
    run("R6 both qnan",  mk(7'b0010111, 3'b000), 1, QNAN, QNAN, 1, CANON, 0, 0);
    run("R7 snan min",   mk(7'b0010111, 3'b000), 1, SNAN, ONE,  1, ONE,   0, NV);
    run("R7 snan,qnan",  mk(7'b0010111, 3'b001), 1, SNAN, QNAN, 1, CANON, 0, NV);
  endtask

  task automatic t_cmp();
    run("R8 eq",        mk(7'b1010011, 3'b010), 1, ONE,  ONE,  1, 0, 1, 0);
    run("R8 eq zeros",  mk(7'b1010011, 3'b010), 1, PZ,   NZ,   1, 0, 1, 0);
    run("R8 lt true",   mk(7'b1010011, 3'b001), 1, ONE,  TWO,  1, 0, 1, 0);
    run("R8 lt false",  mk(7'b1010011, 3'b001), 1, TWO,  ONE,  1, 0, 0, 0);
    run("R8 lt neg",    mk(7'b1010011, 3'b001), 1, NTWO, NONE, 1, 0, 1, 0);
    run("R8 le equal",  mk(7'b1010011, 3'b000), 1, ONE,  ONE,  1, 0, 1, 0);
    run("R8 le zeros",  mk(7'b1010011, 3'b000), 1, NZ,   PZ,   1, 0, 1, 0);
    run("R8 lt zeros",  mk(7'b1010011, 3'b001), 1, NZ,   PZ,   1, 0, 0, 0);
  endtask

  task automatic t_cmp_nan();
    run("R9 eq qnan", mk(7'b1010011, 3'b010), 1, QNAN, ONE,  1, 0, 0, 0);
    run("R9 eq snan", mk(7'b1010011, 3'b010), 1, SNAN, ONE,  1, 0, 0, NV);
    run("R9 lt qnan", mk(7'b1010011, 3'b001), 1, QNAN, ONE,  1, 0, 0, NV);
    run("R9 le qnan", mk(7'b1010011, 3'b000), 1, ONE,  QNAN, 1, 0, 0, NV);
  endtask

  task automatic t_illegal();
    run("R1 bad funct3", mk(7'b0010011, 3'b011), 1, ONE, TWO, 0, 0, 0, 0);
    run("R1 bad opcode", {mk(7'b0010111, 3'b000)} ^ 32'h1, 1, ONE, TWO, 0, 0, 0, 0);
    run("R1 no valid",   mk(7'b1010011, 3'b010), 0, ONE, ONE, 0, 0, 0, 0);
    run("R1 minmax f3",  mk(7'b0010111, 3'b010), 1, SNAN, ONE, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sgnj();
    t_minmax();
    t_zero();
    t_nan_mm();
    t_cmp();
    t_cmp_nan();
    t_illegal();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule